// File: doc/BRIEF.md
# Pipelined Phase Accumulator for a Numerically Controlled Oscillator

This block produces the running phase of a numerically controlled oscillator. A tuning step, loaded byte by byte from a small controller bus into a holding register and then committed as one word, is added to the phase on every enabled clock. The phase is a 32-bit value that wraps modulo 2^32. The oscillator frequency is therefore step × f_clk / 2^32, and a step of 1 is the finest frequency resolution. The top 13 phase bits address an 8192-entry waveform table that sits outside this block.

The wide adder does not fit in one clock period at high rates, so the feedback sum is split into four 8-bit slices. Each slice registers its carry for the next slice, which works one clock later. The step bytes are delayed to follow that carry wavefront. The slice outputs are then realigned, so the phase and address seen at the outputs are always one coherent value. The cost is a fixed latency of three cycles on the phase output. A committed step reaches the output increments four enabled cycles after the commit.

Top module: `dds_phase_acc`

## Requirements
- R1: On every enabled clock the internal phase advances by the active step, modulo 2^32, with no overflow indication. The output `phase_o` presents that phase three enabled clocks late, so consecutive output values always differ by a whole step.
- R2: `addr_o` equals bits 31..19 of `phase_o` at all times. With a step of 0x0008_0000 the address advances by exactly 1 per enabled clock and wraps from 8191 to 0.
- R3: If `commit_i` is high at clock edge E, the output increments after edges E, E+1, E+2 and E+3 still equal the old step. The increment after edge E+4 is the first one equal to the new step, provided all those edges are enabled.
- R4: A write with `wr_i` high stores `wr_data_i` into byte `wr_sel_i` of the holding register. Select 0 is bits 7..0 and select 3 is bits 31..24. Writes alone never change the phase increments; only `commit_i` copies the whole holding register into the active step.
- R5: When `wr_i` and `commit_i` are high on the same edge, the commit takes the holding register as it stood before that write. The written byte takes effect at the next commit.
- R6: While `en_i` is low, `phase_o` and `addr_o` hold their values and the pipeline is frozen. When `en_i` returns high, the phase sequence continues exactly as if the idle cycles had not occurred.
- R7: Asserting `rst_ni` low clears the phase, all carries, the holding register and the active step to zero. After reset the phase stays at zero until a nonzero step is committed.
- R8: Around a step change, every output increment is either the whole old step or the whole new step. No increment mixes bytes of both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable; low freezes the phase pipeline |
| wr_i | input | 1 | Write one byte of the holding register |
| wr_sel_i | input | 2 | Byte index of the write (0 = least significant) |
| wr_data_i | input | 8 | Byte written |
| commit_i | input | 1 | Copy the holding register into the active step |
| phase_o | output | 32 | Aligned phase |
| addr_o | output | 13 | Waveform-table address, top 13 bits of the phase |

## Verification
On every cycle, the bound checker verifies four things. The aligned output advances by the step that was active four cycles earlier whenever the pipeline has run without a stall. The top-slice carry marks exactly the cycles where the output phase wraps. A frozen cycle leaves the phase unchanged. The active step changes only on a commit, and then to the prior holding value. The exact switch-over cycle after a commit, the byte placement of writes, the pre-write capture rule, address wrap-around, reset clearing and resumption after a stall all depend on chosen sequences. The bench's directed scenarios show these by comparing against an independent model of the phase.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
  localparam int unsigned PHASE_W_DEF = 32;
  localparam int unsigned SLICE_W_DEF = 8;
  localparam int unsigned ADDR_W_DEF  = 13;
  localparam int unsigned BUS_W_DEF   = 8;
endpackage

// File: rtl/dds_pipe_dly.sv
`timescale 1ns/1ps
module dds_pipe_dly #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] r_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) r_q[i] <= '0;
    end else if (en_i) begin
      r_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) r_q[i] <= r_q[i-1];
    end
  end

  assign q_o = r_q[DEPTH-1];
endmodule

// File: rtl/dds_fcw_regs.sv
`timescale 1ns/1ps
module dds_fcw_regs #(
  parameter  int PHASE_W = 32,
  parameter  int BUS_W   = 8,
  localparam int N_LANE  = PHASE_W / BUS_W,
  localparam int SEL_W   = (N_LANE > 1) ? $clog2(N_LANE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic               commit_i,
  output logic [PHASE_W-1:0] shadow_o,
  output logic [PHASE_W-1:0] step_o
);
  logic [PHASE_W-1:0] shadow_q, step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      step_q   <= '0;
    end else begin
      // commit sees the pre-write holding value (nonblocking)
      if (commit_i) step_q <= shadow_q;
      for (int l = 0; l < N_LANE; l++) begin
        if (wr_i && (sel_i == SEL_W'(l))) shadow_q[l*BUS_W +: BUS_W] <= wdata_i;
      end
    end
  end

  assign shadow_o = shadow_q;
  assign step_o   = step_q;
endmodule

// File: rtl/dds_acc_slice.sv
`timescale 1ns/1ps
module dds_acc_slice #(
  parameter int W   = 8,
  parameter int IDX = 0,
  parameter int N   = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] step_i,
  input  logic         cin_i,
  output logic         cout_o,
  output logic [W-1:0] q_o
);
  localparam int SKEW_IN  = IDX;
  localparam int SKEW_OUT = N - 1 - IDX;

  logic [W-1:0] step_d;
  logic [W-1:0] acc_q;
  logic         cy_q;
  logic [W:0]   sum_w;

  // step byte follows the carry wavefront
  if (SKEW_IN == 0) begin : g_in_direct
    assign step_d = step_i;
  end else begin : g_in_dly
    dds_pipe_dly #(.W(W), .DEPTH(SKEW_IN)) u_in_dly (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .d_i   (step_i),
      .q_o   (step_d)
    );
  end

  always_comb sum_w = {1'b0, acc_q} + {1'b0, step_d} + {{W{1'b0}}, cin_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (en_i) begin
      acc_q <= sum_w[W-1:0];
      cy_q  <= sum_w[W];
    end
  end

  assign cout_o = cy_q;

  // realign so all slices show the same phase sample
  if (SKEW_OUT == 0) begin : g_out_direct
    assign q_o = acc_q;
  end else begin : g_out_dly
    dds_pipe_dly #(.W(W), .DEPTH(SKEW_OUT)) u_out_dly (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .d_i   (acc_q),
      .q_o   (q_o)
    );
  end
endmodule

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
  parameter  int PHASE_W = dds_pkg::PHASE_W_DEF,
  parameter  int SLICE_W = dds_pkg::SLICE_W_DEF,
  parameter  int ADDR_W  = dds_pkg::ADDR_W_DEF,
  parameter  int BUS_W   = dds_pkg::BUS_W_DEF,
  localparam int N_SLICE = PHASE_W / SLICE_W,
  localparam int N_LANE  = PHASE_W / BUS_W,
  localparam int SEL_W   = (N_LANE > 1) ? $clog2(N_LANE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               wr_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [BUS_W-1:0]   wr_data_i,
  input  logic               commit_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [PHASE_W-1:0] shadow;
  logic [PHASE_W-1:0] step_act;
  logic [N_SLICE-1:0] cy;
  logic [PHASE_W-1:0] phase_al;
  logic               wrap;

  dds_fcw_regs #(.PHASE_W(PHASE_W), .BUS_W(BUS_W)) u_fcw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .sel_i   (wr_sel_i),
    .wdata_i (wr_data_i),
    .commit_i(commit_i),
    .shadow_o(shadow),
    .step_o  (step_act)
  );

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    logic cin;
    if (s == 0) begin : g_c0
      assign cin = 1'b0;
    end else begin : g_cn
      assign cin = cy[s-1];
    end
    dds_acc_slice #(.W(SLICE_W), .IDX(s), .N(N_SLICE)) u_slice (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .step_i(step_act[s*SLICE_W +: SLICE_W]),
      .cin_i (cin),
      .cout_o(cy[s]),
      .q_o   (phase_al[s*SLICE_W +: SLICE_W])
    );
  end

  // top carry is dropped: modulo 2^PHASE_W wrap
  assign wrap    = cy[N_SLICE-1];
  assign phase_o = phase_al;
  assign addr_o  = phase_al[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/dds_phase_acc_chk.sv
`timescale 1ns/1ps
module dds_phase_acc_chk #(
  parameter int PHASE_W = 32,
  parameter int N_SLICE = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               commit_i,
  input logic [PHASE_W-1:0] shadow_i,
  input logic [PHASE_W-1:0] step_i,
  input logic               wrap_i,
  input logic [PHASE_W-1:0] phase_i
);
  if (N_SLICE == 4) begin : g_step4
    p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(en_i, 1) && $past(en_i, 2) && $past(en_i, 3) && $past(en_i, 4))
      |-> ((phase_i - $past(phase_i)) == $past(step_i, 4)));
  end

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> (wrap_i == (phase_i < $past(phase_i))));

  p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> $stable(phase_i));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit_i) |-> $stable(step_i));

  p_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(commit_i) |-> (step_i == $past(shadow_i)));
endmodule

bind dds_phase_acc dds_phase_acc_chk #(.PHASE_W(PHASE_W), .N_SLICE(N_SLICE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .commit_i(commit_i),
  .shadow_i(shadow),
  .step_i  (step_act),
  .wrap_i  (wrap),
  .phase_i (phase_o)
);

// File: tb/tb_dds_phase_acc.sv
`timescale 1ns/1ps
module tb_dds_phase_acc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        commit_i = 1'b0;
  logic [31:0] phase_o;
  logic [12:0] addr_o;

  always #2.5 clk_i = ~clk_i;

  dds_phase_acc dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .wr_i     (wr_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .commit_i (commit_i),
    .phase_o  (phase_o),
    .addr_o   (addr_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model: m_p[0] newest phase, m_p[3] what the outputs show
  logic [31:0] m_shadow = '0;
  logic [31:0] m_step   = '0;
  logic [31:0] m_p [4]  = '{default: '0};
  int          mis = 0;
  logic [31:0] mis_act, mis_exp;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    if (!rst_ni) begin
      m_shadow = '0; m_step = '0;
      for (int i = 0; i < 4; i++) m_p[i] = '0;
    end else begin
      if (en_i) begin
        m_p[3] = m_p[2]; m_p[2] = m_p[1]; m_p[1] = m_p[0];
        m_p[0] = m_p[0] + m_step;
      end
      if (commit_i) m_step = m_shadow;
      if (wr_i) m_shadow[wr_sel_i*8 +: 8] = wr_data_i;
    end
    @(negedge clk_i);
    if (phase_o !== m_p[3] || addr_o !== m_p[3][31:19]) begin
      if (mis == 0) begin mis_act = phase_o; mis_exp = m_p[3]; end
      mis++;
    end
  endtask

  task automatic model_check(input string req);
    check(mis == 0, req, "phase vs model", mis_act, mis_exp);
    mis = 0;
  endtask

  task automatic write_byte(input logic [1:0] s, input logic [7:0] d);
    wr_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    tick();
    wr_i = 1'b0;
  endtask

  task automatic write_word(input logic [31:0] k);
    for (int b = 0; b < 4; b++) write_byte(2'(b), k[b*8 +: 8]);
  endtask

  task automatic commit();
    commit_i = 1'b1;
    tick();
    commit_i = 1'b0;
  endtask

  task automatic load_step(input logic [31:0] k);
    write_word(k);
    commit();
    repeat (6) tick();
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; en_i = 1'b0;
    repeat (5) tick();
    check(phase_o == 32'h0, "R7", "phase in reset", phase_o, 32'h0);
    check(addr_o == 13'h0, "R7", "addr in reset", {19'h0, addr_o}, 32'h0);
    rst_ni = 1'b1; en_i = 1'b1;
    repeat (10) tick();
    check(phase_o == 32'h0, "R7", "phase with zero step", phase_o, 32'h0);
    model_check("R7");
  endtask

  task automatic t_basic();
    logic [31:0] prev;
    load_step(32'h0000_1234);
    prev = phase_o;
    tick();
    check(phase_o - prev == 32'h0000_1234, "R1", "increment", phase_o - prev, 32'h1234);
    repeat (20) tick();
    model_check("R1");
  endtask

  task automatic t_wrap();
    logic [31:0] prev;
    load_step(32'hFFFF_FFFF);
    repeat (5) tick();
    prev = phase_o;
    tick();
    check(phase_o - prev == 32'hFFFF_FFFF, "R1", "decrement by wrap", phase_o - prev, 32'hFFFF_FFFF);
    load_step(32'h8000_0001);
    repeat (30) tick();
    model_check("R1");
  endtask

  task automatic t_latency();
    logic [31:0] prev;
    logic [31:0] d [5];
    load_step(32'h0000_0100);
    write_word(32'h0003_0000);
    prev = phase_o;
    tick();
    check(phase_o - prev == 32'h0000_0100, "R4", "write only keeps step", phase_o - prev, 32'h100);
    commit();
    for (int i = 1; i <= 4; i++) begin
      prev = phase_o;
      tick();
      d[i] = phase_o - prev;
    end
    check(d[3] == 32'h0000_0100, "R3", "old step at E+3", d[3], 32'h100);
    check(d[4] == 32'h0003_0000, "R3", "new step at E+4", d[4], 32'h30000);
    model_check("R3");
  endtask

  task automatic t_precommit();
    logic [31:0] prev;
    write_word(32'h0102_0304);
    wr_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 8'h55; commit_i = 1'b1;
    tick();
    wr_i = 1'b0; commit_i = 1'b0;
    repeat (6) tick();
    prev = phase_o;
    tick();
    check(phase_o - prev == 32'h0102_0304, "R5", "commit takes pre-write value", phase_o - prev, 32'h01020304);
    commit();
    repeat (6) tick();
    prev = phase_o;
    tick();
    check(phase_o - prev == 32'h0102_0355, "R5", "byte applied at next commit", phase_o - prev, 32'h01020355);
    check(addr_o == phase_o[31:19], "R2", "addr is top bits", {19'h0, addr_o}, {19'h0, phase_o[31:19]});
    model_check("R4");
  endtask

  task automatic t_freeze();
    logic [31:0] held;
    bit ok = 1'b1;
    load_step(32'h0123_4567);
    en_i = 1'b0;
    tick();
    held = phase_o;
    for (int i = 0; i < 7; i++) begin
      tick();
      if (phase_o !== held) ok = 1'b0;
    end
    check(ok, "R6", "phase held while idle", phase_o, held);
    en_i = 1'b1;
    repeat (12) tick();
    model_check("R6");
  endtask

  task automatic t_nomix();
    logic [31:0] prev, d;
    bit ok = 1'b1;
    load_step(32'h00FF_FFFF);
    write_word(32'hFF00_0001);
    commit();
    for (int i = 0; i < 8; i++) begin
      prev = phase_o;
      tick();
      d = phase_o - prev;
      if (d != 32'h00FF_FFFF && d != 32'hFF00_0001) ok = 1'b0;
    end
    check(ok, "R8", "increment is whole old or new step", d, 32'hFF00_0001);
    model_check("R8");
  endtask

  task automatic t_addr();
    logic [12:0] pa;
    bit ok = 1'b1;
    bit wrapped = 1'b0;
    load_step(32'h0008_0000);
    for (int i = 0; i < 8300; i++) begin
      pa = addr_o;
      tick();
      if (addr_o != pa + 13'd1) ok = 1'b0;
      if (pa == 13'h1FFF && addr_o == 13'h0) wrapped = 1'b1;
    end
    check(ok, "R2", "address step of one", {19'h0, addr_o}, {19'h0, pa + 13'd1});
    check(wrapped, "R2", "address wrap 8191 to 0", {31'h0, wrapped}, 32'h1);
    model_check("R2");
  endtask

  task automatic t_reset_mid();
    load_step(32'h0BAD_0001);
    write_word(32'h1111_1111);
    rst_ni = 1'b0; en_i = 1'b0;
    repeat (5) tick();
    check(phase_o == 32'h0, "R7", "phase cleared mid run", phase_o, 32'h0);
    rst_ni = 1'b1; en_i = 1'b1;
    repeat (8) tick();
    check(phase_o == 32'h0, "R7", "step cleared", phase_o, 32'h0);
    commit();
    repeat (8) tick();
    check(phase_o == 32'h0, "R7", "holding register cleared", phase_o, 32'h0);
    model_check("R7");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_latency();
    t_precommit();
    t_freeze();
    t_nomix();
    t_addr();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule